// File: doc/BRIEF.md
# Prescaled Capture Timer

This block keeps a free-running 16-bit count that advances on a tick picked from seven power-of-two divisions of the bus clock. Two capture channels watch their own input pins. When a channel sees the transition its edge setting asks for, it copies the count into its capture register, sets its status flag and, if its interrupt enable is on, raises its interrupt line.

Software reaches the block through a byte-wide bus port. One control register holds the rate selector. Each channel has one status/control byte and a capture register that is read as two bytes. A flag is cleared by a two-step handshake. Reading a high byte holds the matching low byte, so a 16-bit readout stays coherent even while new captures arrive.

Top module: `capture_timer`

## Requirements
- R1: After reset every readable register (addresses 0 to 7) reads 0, and both interrupt outputs are low.
- R2: Rate selector values 0 through 6 advance the count once every 1, 2, 4, 8, 16, 32 and 64 bus cycles. Over any window of 128 cycles the count therefore grows by 128 shifted right by the selector. The count wraps at 16 bits.
- R3: Rate selector value 7 stops the count.
- R4: The two channels hold separate settings, flags and capture registers. A change on one channel leaves the other channel unchanged. Given the same pin timing, both channels latch the same count.
- R5: The edge field is status bits [1:0]. Value 00 ignores the pin, 01 captures on rising edges, 10 captures on falling edges and 11 captures on both.
- R6: A pin change made between two clock edges shows up in the flag and the capture register after the second rising clock edge that follows it, and not after the first.
- R7: Every qualifying edge overwrites the capture register and sets the flag, even when the flag is already set.
- R8: The status byte holds the flag in bit 7, the interrupt enable in bit 6 and the edge field in bits [1:0]; its other bits read 0. The interrupt output of a channel is high exactly when its flag and its enable are both set.
- R9: A write of 0 to the flag bit clears the flag only if the status byte was read while the flag was set, after the last such write. Writing 1 to the flag bit leaves it unchanged.
- R10: If a capture and a valid clear land on the same clock edge, the flag stays set.
- R11: Reading a capture high byte holds the low byte as it was at that moment. The held value is returned until that low byte is read; after that the low byte is live again.
- R12: Register map: address 0 is the control register, with the rate selector in bits [2:0]. Addresses 1 and 2 are the status bytes of channels 0 and 1. Addresses 3 and 4 are the high and low capture bytes of channel 0, and addresses 5 and 6 those of channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; drives the flag-clear arming and the low-byte hold |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cap_pin | input | 2 | Capture input pins, one per channel |
| irq | output | 2 | Interrupt requests, one per channel |

## Verification
Some rules are checked by assertions on every cycle:
- the count never moves under the reserved selector and never steps by more than one;
- a capture register never changes without its flag being set;
- a disabled channel never captures;
- a flag only falls after it was armed by a read;
- a held low byte stays put;
- a capture that lands on the same edge as a clear keeps the flag.

The division ratios, the exact two-edge latency, the edge-polarity choices, the clear handshake at the ports and the coherent two-byte readout can only be shown by the bench. It places pin changes at known cycle offsets and reads the results back over the bus.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
      return (rise && (sel == EDGE_RISE || sel == EDGE_ANY)) ||
             (fall && (sel == EDGE_FALL || sel == EDGE_ANY));
   endfunction

endpackage

// File: rtl/tc_timebase.sv
`timescale 1ns/1ps
module tc_timebase #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned NUM_RATES = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] rate_sel,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned PRE_W = (NUM_RATES > 1) ? NUM_RATES - 1 : 1;

   logic             tick;
   logic [CNT_W-1:0] count_q;

   generate
      if (NUM_RATES < 1 || NUM_RATES > (1 << SEL_W)) begin : g_bad_rates
         $error("tc_timebase: NUM_RATES does not fit the selector");
      end
      if (CNT_W < 2) begin : g_bad_width
         $error("tc_timebase: CNT_W too small");
      end

      if (NUM_RATES == 1) begin : g_direct
         assign tick = (rate_sel == '0);
      end else begin : g_scaled
         logic [PRE_W-1:0] pre_q;

         function automatic logic [PRE_W-1:0] rate_mask(int k);
            return PRE_W'((1 << k) - 1);
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= pre_q + 1'b1;
         end

         always_comb begin
            tick = 1'b0;
            for (int k = 0; k < NUM_RATES; k++) begin
               if (rate_sel == SEL_W'(k))
                  tick = ((pre_q & rate_mask(k)) == rate_mask(k));
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (tick) count_q <= count_q + 1'b1;
   end

   assign count = count_q;

   // R3: a reserved selector freezes the count
   assert_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel >= NUM_RATES) |=> $stable(count_q));

   // R2: the count moves by at most one step per bus cycle
   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/tc_capture_ch.sv
`timescale 1ns/1ps
module tc_capture_ch
   import tc_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pin,
   input  logic [2*DATA_W-1:0] count,
   input  logic                stat_wr,
   input  logic                stat_rd,
   input  logic                hi_rd,
   input  logic                lo_rd,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   stat_byte,
   output logic [DATA_W-1:0]   hi_byte,
   output logic [DATA_W-1:0]   lo_byte,
   output logic                irq
);
   localparam int unsigned CNT_W  = 2 * DATA_W;
   localparam int unsigned FLAG_B = DATA_W - 1;
   localparam int unsigned IE_B   = DATA_W - 2;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("tc_capture_ch: DATA_W must leave room for flag, enable and edge field");
      end
   endgenerate

   logic              s1_q, s2_q;
   logic              rise, fall, hit, clr;
   edge_sel_e         esel_q;
   logic              ie_q, flag_q, armed_q, frozen_q;
   logic [CNT_W-1:0]  cap_q;
   logic [DATA_W-1:0] hold_q;
   logic              wr_unused;

   assign wr_unused = ^wr_data[DATA_W-3:2];

   // one sampling stage plus a history stage: two edges of latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
      end else begin
         s1_q <= pin;
         s2_q <= s1_q;
      end
   end

   assign rise = s1_q & ~s2_q;
   assign fall = ~s1_q & s2_q;
   assign hit  = edge_hit(esel_q, rise, fall);
   assign clr  = stat_wr && !wr_data[FLAG_B] && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         esel_q  <= EDGE_OFF;
         ie_q    <= 1'b0;
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
         cap_q   <= '0;
      end else begin
         if (stat_wr) begin
            esel_q <= edge_sel_e'(wr_data[1:0]);
            ie_q   <= wr_data[IE_B];
         end
         if (hit) begin
            cap_q  <= count;
            flag_q <= 1'b1;
         end else if (clr) begin
            flag_q <= 1'b0;
         end
         if (stat_wr && !wr_data[FLAG_B]) armed_q <= 1'b0;
         else if (stat_rd && flag_q)      armed_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frozen_q <= 1'b0;
         hold_q   <= '0;
      end else if (hi_rd) begin
         frozen_q <= 1'b1;
         hold_q   <= cap_q[DATA_W-1:0];
      end else if (lo_rd) begin
         frozen_q <= 1'b0;
      end
   end

   always_comb begin
      stat_byte         = '0;
      stat_byte[FLAG_B] = flag_q;
      stat_byte[IE_B]   = ie_q;
      stat_byte[1:0]    = esel_q;
   end

   assign hi_byte = cap_q[CNT_W-1:DATA_W];
   assign lo_byte = frozen_q ? hold_q : cap_q[DATA_W-1:0];
   assign irq     = flag_q & ie_q;

   // R7: a new capture value always comes with a set flag
   assert_capture_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_q) |-> flag_q);

   // R5: a disabled channel never captures
   assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (esel_q == EDGE_OFF) |=> $stable(cap_q));

   // R9: the flag only falls after a read armed the clear
   assert_clear_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(armed_q));

   // R10: a capture that meets a clear keeps the flag
   assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr) |=> flag_q);

   // R11: the held low byte stays put until released
   assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_q && !hi_rd) |=> $stable(hold_q));

endmodule

// File: rtl/capture_timer.sv
`timescale 1ns/1ps
module capture_timer #(
   parameter  int unsigned NUM_CH    = 2,
   parameter  int unsigned DATA_W    = 8,
   parameter  int unsigned SEL_W     = 3,
   parameter  int unsigned NUM_RATES = 7,
   localparam int unsigned CNT_W     = 2 * DATA_W,
   localparam int unsigned NUM_REGS  = 1 + 3 * NUM_CH,
   localparam int unsigned ADDR_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] cap_pin,
   output logic [NUM_CH-1:0] irq
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("capture_timer: need at least one channel");
      end
      if (SEL_W > DATA_W) begin : g_bad_sel
         $error("capture_timer: selector wider than the data bus");
      end
   endgenerate

   logic [SEL_W-1:0]  sel_q;
   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] stat_b [NUM_CH];
   logic [DATA_W-1:0] hi_b   [NUM_CH];
   logic [DATA_W-1:0] lo_b   [NUM_CH];
   logic              wdata_unused;

   assign wdata_unused = ^bus_wdata[DATA_W-1:SEL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        sel_q <= '0;
      else if (bus_wr && bus_addr == '0) sel_q <= bus_wdata[SEL_W-1:0];
   end

   tc_timebase #(
      .CNT_W     (CNT_W),
      .SEL_W     (SEL_W),
      .NUM_RATES (NUM_RATES)
   ) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (sel_q),
      .count    (count)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         localparam int unsigned STAT_A = 1 + ch;
         localparam int unsigned HI_A   = 1 + NUM_CH + 2 * ch;
         localparam int unsigned LO_A   = HI_A + 1;

         tc_capture_ch #(
            .DATA_W (DATA_W)
         ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (cap_pin[ch]),
            .count     (count),
            .stat_wr   (bus_wr && bus_addr == ADDR_W'(STAT_A)),
            .stat_rd   (bus_rd && bus_addr == ADDR_W'(STAT_A)),
            .hi_rd     (bus_rd && bus_addr == ADDR_W'(HI_A)),
            .lo_rd     (bus_rd && bus_addr == ADDR_W'(LO_A)),
            .wr_data   (bus_wdata),
            .stat_byte (stat_b[ch]),
            .hi_byte   (hi_b[ch]),
            .lo_byte   (lo_b[ch]),
            .irq       (irq[ch])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) bus_rdata = DATA_W'(sel_q);
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ADDR_W'(1 + c))              bus_rdata = stat_b[c];
         if (bus_addr == ADDR_W'(1 + NUM_CH + 2 * c)) bus_rdata = hi_b[c];
         if (bus_addr == ADDR_W'(2 + NUM_CH + 2 * c)) bus_rdata = lo_b[c];
      end
   end

endmodule

// File: tb/tb_capture_timer.sv
`timescale 1ns/1ps
module tb_capture_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic [1:0] cap_pin = '0;
   logic [1:0] irq;

   int total = 0;
   int bad   = 0;
   logic mon_chk = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
      logic [2:0] addr;
   } sb_item_t;
   sb_item_t sb_q[$];

   always #2.5 clk = ~clk;

   capture_timer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .cap_pin   (cap_pin),
      .irq       (irq)
   );

   // monitor: pops one expected item per scored read cycle
   always @(negedge clk) begin
      #1;
      if (mon_chk) begin
         total++;
         if (sb_q.size() == 0) begin
            bad++;
            $display("FAIL scoreboard: read with nothing expected, actual %h", bus_rdata);
         end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            if (bus_rdata !== it.exp) begin
               bad++;
               $display("FAIL %s: addr %0d actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic quiet();
      bus_wr = 1'b0; bus_rd = 1'b0; mon_chk = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         quiet();
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      quiet();
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      quiet();
      bus_addr = a; bus_rd = 1'b1;
      sb_q.push_back('{exp: e, tag: tag, addr: a});
      mon_chk = 1'b1;
   endtask

   task automatic rd_get(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      quiet();
      bus_addr = a; bus_rd = 1'b1;
      #1;
      v = bus_rdata;
   endtask

   task automatic get_cap(input int ch, output logic [15:0] v);
      logic [7:0] h, l;
      rd_get(3'(3 + 2 * ch), h);
      rd_get(3'(4 + 2 * ch), l);
      v = {h, l};
   endtask

   task automatic set_pin(input int ch, input logic v);
      @(negedge clk);
      quiet();
      cap_pin[ch] = v;
   endtask

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [15:0] a, b, v0;
      logic [7:0]  alo;
      logic        p;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R12: reset contents of every address
      for (int i = 0; i < 8; i++) rd(3'(i), 8'h00, "R1");
      idle(1);
      chk({14'd0, irq}, 16'd0, "R1");

      // both channels on either edge, enables off
      wr(1, 8'h83);
      wr(2, 8'h83);

      // R6: visible after the second edge only
      set_pin(0, 1'b1);
      rd(1, 8'h03, "R6");
      rd(1, 8'h83, "R6");

      // R4 / R2: equal pin timing gives equal counts, divide by one
      set_pin(0, 1'b0);
      idle(4);
      set_pin(1, 1'b1);
      idle(3);
      get_cap(0, v0);
      get_cap(1, b);
      chk(b - v0, 16'd5, "R4");
      rd(2, 8'h83, "R4");

      // R4 / R5: channel 0 off, channel 1 still captures
      wr(1, 8'h80);
      set_pin(0, 1'b1);
      set_pin(1, 1'b0);
      idle(3);
      rd(3, v0[15:8], "R4");
      rd(4, v0[7:0], "R4");
      rd(1, 8'h80, "R5");

      // R9: armed clears on both channels
      wr(1, 8'h03);
      rd(1, 8'h03, "R9");
      wr(2, 8'h01);
      rd(2, 8'h01, "R9");

      // R5: polarity choices on channel 1
      set_pin(1, 1'b1); idle(3);
      rd(2, 8'h81, "R5");
      wr(2, 8'h01);
      set_pin(1, 1'b0); idle(3);
      rd(2, 8'h01, "R5");
      wr(2, 8'h82);
      set_pin(1, 1'b1); idle(3);
      rd(2, 8'h02, "R5");
      set_pin(1, 1'b0); idle(3);
      rd(2, 8'h82, "R5");
      wr(2, 8'h83);

      // R7: overwrite while flag set
      set_pin(0, 1'b0);
      idle(3);
      get_cap(0, a);
      set_pin(0, 1'b1);
      idle(3);
      b = a + 16'd6;
      rd(3, b[15:8], "R7");
      rd(4, b[7:0], "R7");
      rd(1, 8'h83, "R7");

      // R8: interrupt gating and status layout
      idle(1);
      chk({15'd0, irq[0]}, 16'd0, "R8");
      wr(1, 8'hC3);
      idle(1);
      chk({15'd0, irq[0]}, 16'd1, "R8");
      rd(1, 8'hC3, "R8");
      chk({15'd0, irq[1]}, 16'd0, "R8");

      // R9: clear handshake
      wr(1, 8'h43);
      idle(1);
      chk({15'd0, irq[0]}, 16'd0, "R9");
      set_pin(0, 1'b0);
      idle(3);
      chk({15'd0, irq[0]}, 16'd1, "R9");
      wr(1, 8'h43);
      idle(1);
      chk({15'd0, irq[0]}, 16'd1, "R9");
      rd(1, 8'hC3, "R9");
      wr(1, 8'h43);
      idle(1);
      rd(1, 8'h43, "R9");

      // R10: capture on the same edge as the clear
      set_pin(0, 1'b1);
      idle(3);
      rd(1, 8'hC3, "R10");
      set_pin(0, 1'b0);
      wr(1, 8'h43);
      idle(1);
      rd(1, 8'hC3, "R10");

      // R11: coherent two-byte read on channel 1
      set_pin(1, 1'b1);
      idle(3);
      get_cap(1, a);
      alo = a[7:0];
      rd(5, a[15:8], "R11");
      set_pin(1, 1'b0);
      idle(3);
      rd(6, alo, "R11");
      b = a + 16'd7;
      rd(5, b[15:8], "R11");
      rd(6, b[7:0], "R11");

      // R2 / R3: every rate over a 128-cycle window
      p = 1'b0;
      for (int k = 0; k < 8; k++) begin
         wr(0, 8'(k));
         rd(0, 8'(k), "R12");
         idle(2);
         p = ~p;
         set_pin(0, p);
         idle(3);
         get_cap(0, a);
         idle(122);
         p = ~p;
         set_pin(0, p);
         idle(3);
         get_cap(0, b);
         if (k == 7) chk(b - a, 16'd0, "R3");
         else        chk(b - a, 16'(128 >> k), "R2");
      end
      wr(0, 8'h00);
      idle(2);
      finish_run();
   end

endmodule